// File: doc/BRIEF.md
# SPI Master Command-Queue Sequencer

This block is a SPI master that runs a queue of commands on its own. Software, or a bus mover, pushes entries into a four-deep transmit FIFO. Each entry holds an 8-bit data word and three command bits: end-of-queue, zero-counter and hold-select. Whenever the block is running and an entry is waiting, the engine takes that entry and sends it as one mode-0 frame. The word received during the frame goes into a four-deep receive FIFO. A 16-bit transfer counter goes up by one for each finished frame.

An entry marked end-of-queue sets a sticky flag when its frame finishes. While that flag is set, the block starts no new frame and shows that it is stopped. The transmit FIFO keeps taking new entries while the block is stopped. Software then drains the receive side, which it can watch through the fill level and the not-empty flag. It can flush either FIFO and reset the counter, either through a command bit or through a direct write. Writing a one to the flag-clear input restarts serial activity.

Top module: `spi_cmdq_master`

## Requirements
- R1: After reset the block shows running_o=1, eoq_flag_o=0, cs_no=1, sck_o=0, xfer_cnt_o=0, rx_level_o=0, rx_avail_o=0, tx_full_o=0 and rx_data_o=0.
- R2: Each frame is 8 bits, sent MSB first in mode 0. SCK idles low, MISO is sampled on the rising edge, and MOSI changes on the falling edge. The SCK period is 2·N clocks, where N is div_i and a div_i of 0 counts as 1.
- R3: The word received in each frame is placed in the RX FIFO. rx_data_o shows the oldest word, and rx_pop_i removes it. rx_data_o reads 0 when the RX FIFO is empty, and a pop while empty has no effect.
- R4: Each FIFO holds 4 entries. tx_full_o is high when 4 entries are stored. A push while the FIFO is full is dropped, and that entry is never sent.
- R5: xfer_cnt_o goes up by one when each frame completes and wraps from 0xFFFF to 0. cnt_wr_i loads cnt_wdata_i into the counter and takes priority over any change in the same cycle.
- R6: An entry with tx_zero_cnt_i set clears the counter when its frame starts, so the counter reads 1 after that frame.
- R7: When a frame whose entry has tx_last_i set completes, eoq_flag_o becomes 1 and running_o becomes 0. No frame starts, and SCK and chip select stay idle, until the flag is cleared. Pushes are still accepted while stopped.
- R8: A one-cycle pulse on eoq_clr_i clears eoq_flag_o, and serial transfers of the waiting entries resume.
- R9: tx_flush_i empties the TX FIFO and rx_flush_i empties the RX FIFO. A push in the same cycle as a flush is dropped.
- R10: cs_no is low for the whole of every frame. It goes high after a frame unless that entry had tx_hold_cs_i set. An end-of-queue entry always releases it.
- R11: rx_level_o gives the number of stored received words (0 to 4), and rx_avail_o is high whenever that number is not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | 8 | SCK half-period in clocks (0 treated as 1) |
| tx_push_i | input | 1 | Push one entry into the TX FIFO |
| tx_data_i | input | 8 | Data word of the pushed entry |
| tx_last_i | input | 1 | Entry ends the current queue |
| tx_zero_cnt_i | input | 1 | Entry clears the transfer counter at its start |
| tx_hold_cs_i | input | 1 | Keep chip select asserted after this entry |
| tx_full_o | output | 1 | TX FIFO holds 4 entries |
| rx_pop_i | input | 1 | Remove the oldest received word |
| rx_data_o | output | 8 | Oldest received word, 0 when empty |
| rx_level_o | output | 3 | Received words stored |
| rx_avail_o | output | 1 | RX FIFO not empty |
| tx_flush_i | input | 1 | Empty the TX FIFO |
| rx_flush_i | input | 1 | Empty the RX FIFO |
| eoq_clr_i | input | 1 | Clear the end-of-queue flag |
| cnt_wr_i | input | 1 | Load the transfer counter |
| cnt_wdata_i | input | 16 | Value for the counter load |
| xfer_cnt_o | output | 16 | Transfer counter |
| running_o | output | 1 | Engine may start frames |
| eoq_flag_o | output | 1 | Sticky end-of-queue flag |
| sck_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data out |
| miso_i | input | 1 | SPI data in |
| cs_no | output | 1 | Chip select, active low |

## Verification
Three queue shapes drive the main function. The first is a plain three-entry queue. The second is a four-entry queue pushed while stopped, with a hold-select entry and a dropped fifth push. The third is a single-entry queue pushed after a flush. The first shows per-frame chip-select release and counting. The second shows that the hold bit bridges frames and that the fill level reaches the full depth. The third shows that flushed entries never reach the wire. Single-entry queues at divisors 0 and 3 confirm that the SCK period tracks the divisor, including the zero case. A slave model sends a byte pattern that depends on the frame index, so received words that are reordered or shifted by one bit are caught.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  localparam int unsigned FRAME_W = 8;

  typedef struct packed {
    logic               hold_cs;
    logic               zero_cnt;
    logic               last;
    logic [FRAME_W-1:0] data;
  } cmd_entry_t;
endpackage

// File: rtl/spiq_fifo.sv
module spiq_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [W-1:0]  dout_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [LW-1:0] level_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          wr_en, rd_en;

  assign full_o  = (lvl_q == LW'(DEPTH));
  assign empty_o = (lvl_q == '0);
  assign level_o = lvl_q;
  assign dout_o  = empty_o ? '0 : mem_q[rd_q];
  assign wr_en   = push_i & ~full_o & ~flush_i;
  assign rd_en   = pop_i & ~empty_o & ~flush_i;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    lvl_d = lvl_q;
    if (flush_i) begin
      rd_d  = '0;
      wr_d  = '0;
      lvl_d = '0;
    end else begin
      if (wr_en) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
      if (rd_en) rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
      lvl_d = lvl_q + LW'(wr_en) - LW'(rd_en);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      lvl_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_q] <= din_i;
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= LW'(DEPTH));

  // R4
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !flush_i |=> lvl_q == $past(lvl_q));

  // R9
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/spiq_shifter.sv
module spiq_shifter #(
  parameter int unsigned FRAME_W = 8,
  parameter int unsigned DIV_W   = 8,
  localparam int unsigned PW     = $clog2(2 * FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] load_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               miso_i,
  output logic               sck_o,
  output logic               mosi_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_o
);
  logic               busy_q, busy_d, sck_q, sck_d, tick;
  logic [DIV_W-1:0]   hc_q, hc_d, half_lim;
  logic [PW-1:0]      ph_q, ph_d;
  logic [FRAME_W-1:0] txs_q, txs_d, rxs_q, rxs_d;

  assign half_lim = (div_i == '0) ? DIV_W'(1) : div_i;
  assign tick     = busy_q && (hc_q == half_lim - DIV_W'(1));
  assign done_o   = tick && (ph_q == PW'(2 * FRAME_W - 1));
  assign sck_o    = sck_q;
  assign mosi_o   = txs_q[FRAME_W-1];
  assign busy_o   = busy_q;
  assign rx_o     = rxs_q;

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    hc_d   = hc_q;
    ph_d   = ph_q;
    txs_d  = txs_q;
    rxs_d  = rxs_q;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        txs_d  = load_i;
        hc_d   = '0;
        ph_d   = '0;
        sck_d  = 1'b0;
      end
    end else if (tick) begin
      hc_d  = '0;
      sck_d = ~sck_q;
      ph_d  = ph_q + PW'(1);
      if (!sck_q) rxs_d = {rxs_q[FRAME_W-2:0], miso_i};
      else        txs_d = {txs_q[FRAME_W-2:0], 1'b0};
      if (done_o) busy_d = 1'b0;
    end else begin
      hc_d = hc_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      hc_q   <= '0;
      ph_q   <= '0;
      txs_q  <= '0;
      rxs_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      hc_q   <= hc_d;
      ph_q   <= ph_d;
      txs_q  <= txs_d;
      rxs_q  <= rxs_d;
    end
  end

  // R2
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q);

  // R2
  sck_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !tick |=> $stable(sck_q));

  // R2
  frame_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sck_q);
endmodule

// File: rtl/spi_cmdq_master.sv
module spi_cmdq_master
  import spiq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DIV_W      = 8,
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               tx_push_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  input  logic               tx_last_i,
  input  logic               tx_zero_cnt_i,
  input  logic               tx_hold_cs_i,
  output logic               tx_full_o,
  input  logic               rx_pop_i,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic [LVL_W-1:0]   rx_level_o,
  output logic               rx_avail_o,
  input  logic               tx_flush_i,
  input  logic               rx_flush_i,
  input  logic               eoq_clr_i,
  input  logic               cnt_wr_i,
  input  logic [CNT_W-1:0]   cnt_wdata_i,
  output logic [CNT_W-1:0]   xfer_cnt_o,
  output logic               running_o,
  output logic               eoq_flag_o,
  output logic               sck_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic               cs_no
);
  cmd_entry_t         push_ent, head_ent;
  logic               tx_empty, rx_empty, rx_full, start;
  logic               eng_busy, eng_done;
  logic [FRAME_W-1:0] eng_rx;
  logic [LVL_W-1:0]   tx_lvl;
  logic               eoq_q, eoq_d, cs_n_q, cs_n_d;
  logic               hold_q, hold_d, last_q, last_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  assign push_ent = '{hold_cs: tx_hold_cs_i, zero_cnt: tx_zero_cnt_i,
                      last: tx_last_i, data: tx_data_i};
  assign start    = ~eng_busy & ~eoq_q & ~tx_empty;

  spiq_fifo #(.W($bits(cmd_entry_t)), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk_i, .rst_ni, .push_i(tx_push_i), .din_i(push_ent), .pop_i(start),
    .flush_i(tx_flush_i), .dout_o(head_ent), .full_o(tx_full_o),
    .empty_o(tx_empty), .level_o(tx_lvl));

  spiq_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk_i, .rst_ni, .push_i(eng_done & ~rx_full), .din_i(eng_rx),
    .pop_i(rx_pop_i), .flush_i(rx_flush_i), .dout_o(rx_data_o),
    .full_o(rx_full), .empty_o(rx_empty), .level_o(rx_level_o));

  spiq_shifter #(.FRAME_W(FRAME_W), .DIV_W(DIV_W)) shifter_i (
    .clk_i, .rst_ni, .start_i(start), .load_i(head_ent.data), .div_i,
    .miso_i, .sck_o, .mosi_o, .busy_o(eng_busy), .done_o(eng_done),
    .rx_o(eng_rx));

  always_comb begin
    eoq_d  = eoq_q;
    cs_n_d = cs_n_q;
    hold_d = hold_q;
    last_d = last_q;
    cnt_d  = cnt_q;
    if (eoq_clr_i) eoq_d = 1'b0;
    if (start) begin
      cs_n_d = 1'b0;
      hold_d = head_ent.hold_cs;
      last_d = head_ent.last;
      if (head_ent.zero_cnt) cnt_d = '0;
    end
    if (eng_done) begin
      cnt_d = cnt_q + CNT_W'(1);
      if (!hold_q || last_q) cs_n_d = 1'b1;
      if (last_q) eoq_d = 1'b1;
    end
    if (cnt_wr_i) cnt_d = cnt_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoq_q  <= 1'b0;
      cs_n_q <= 1'b1;
      hold_q <= 1'b0;
      last_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      eoq_q  <= eoq_d;
      cs_n_q <= cs_n_d;
      hold_q <= hold_d;
      last_q <= last_d;
      cnt_q  <= cnt_d;
    end
  end

  assign xfer_cnt_o = cnt_q;
  assign eoq_flag_o = eoq_q;
  assign running_o  = ~eoq_q;
  assign cs_no      = cs_n_q;
  assign rx_avail_o = ~rx_empty;

  // R7
  halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoq_q |-> !eng_busy && cs_n_q);

  // R10
  cs_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_busy |-> !cs_n_q);

  // R5
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done && !cnt_wr_i |=> xfer_cnt_o == $past(xfer_cnt_o) + CNT_W'(1));

  // R6
  zero_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start && head_ent.zero_cnt && !cnt_wr_i |=> xfer_cnt_o == '0);

  // R8
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoq_clr_i && !(eng_done && last_q) |=> !eoq_flag_o);

  // R4
  tx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_lvl <= LVL_W'(FIFO_DEPTH));
endmodule

// File: tb/spi_cmdq_master_tb.sv
`timescale 1ns/1ps
module spi_cmdq_master_tb_top;
  logic        clk, rst_n;
  logic [7:0]  div_b;
  logic        push, last, zero, hold, tx_full;
  logic [7:0]  tdata;
  logic        pop, avail;
  logic [7:0]  rdata;
  logic [2:0]  rlevel;
  logic        tflush, rflush, eclr, cwr, running, eoq;
  logic [15:0] cwdata, cnt;
  logic        sck, mosi, miso, csn;

  int checks = 0, errors = 0;
  int tot = 0, cs_rises = 0;
  time last_rise = 0;
  logic [7:0] shin = '0;
  logic [7:0] cur_resp;
  logic [7:0] exp_mosi[$];
  logic [7:0] exp_rx[$];

  spi_cmdq_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div_b), .tx_push_i(push),
    .tx_data_i(tdata), .tx_last_i(last), .tx_zero_cnt_i(zero),
    .tx_hold_cs_i(hold), .tx_full_o(tx_full), .rx_pop_i(pop),
    .rx_data_o(rdata), .rx_level_o(rlevel), .rx_avail_o(avail),
    .tx_flush_i(tflush), .rx_flush_i(rflush), .eoq_clr_i(eclr),
    .cnt_wr_i(cwr), .cnt_wdata_i(cwdata), .xfer_cnt_o(cnt),
    .running_o(running), .eoq_flag_o(eoq), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .cs_no(csn));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] resp_byte(int i);
    return 8'((i * 29 + 90) ^ 51);
  endfunction

  assign cur_resp = resp_byte(tot / 8);
  assign miso     = cur_resp[3'(7 - (tot % 8))];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // slave monitor: scoreboard for MOSI frames, period and select checks
  always @(posedge csn) cs_rises++;
  always @(posedge sck) begin
    int neff;
    neff = (div_b == 0) ? 1 : int'(div_b);
    chk(csn === 1'b0, "R10", "cs low at sck rise", csn, 0);
    if (tot % 8 != 0)
      chk(($time - last_rise) == time'(2 * neff * 20), "R2", "sck period",
          $time - last_rise, 2 * neff * 20);
    last_rise = $time;
    shin = {shin[6:0], mosi};
    tot++;
    if (tot % 8 == 0) begin
      if (exp_mosi.size() == 0) chk(0, "R4", "unexpected frame", shin, 0);
      else begin
        logic [7:0] e;
        e = exp_mosi.pop_front();
        chk(shin == e, "R2", "mosi frame msb first", shin, e);
      end
      exp_rx.push_back(resp_byte(tot / 8 - 1));
    end
  end

  task automatic push_ent(logic [7:0] d, bit l, bit z, bit h, bit sent);
    @(negedge clk);
    push = 1; tdata = d; last = l; zero = z; hold = h;
    if (sent) exp_mosi.push_back(d);
    @(negedge clk);
    push = 0; last = 0; zero = 0; hold = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); eclr = 1;
    @(negedge clk); eclr = 0;
  endtask

  task automatic wait_eoq();
    @(negedge clk);
    while (!eoq) @(negedge clk);
  endtask

  task automatic write_cnt(logic [15:0] v);
    @(negedge clk); cwr = 1; cwdata = v;
    @(negedge clk); cwr = 0;
  endtask

  task automatic pop_chk();
    logic [7:0] e;
    @(negedge clk);
    e = exp_rx.pop_front();
    chk(avail == 1'b1, "R11", "rx_avail before pop", avail, 1);
    chk(rdata == e, "R3", "rx word", rdata, e);
    pop = 1;
    @(negedge clk);
    pop = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int snap_cs, snap_tot;
    rst_n = 0; div_b = 8'd2; push = 0; last = 0; zero = 0; hold = 0; tdata = 0;
    pop = 0; tflush = 0; rflush = 0; eclr = 0; cwr = 0; cwdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(running == 1 && eoq == 0, "R1", "running/eoq", {running, eoq}, 2'b10);
    chk(csn == 1 && sck == 0, "R1", "cs/sck idle", {csn, sck}, 2'b10);
    chk(cnt == 0 && rlevel == 0 && avail == 0, "R1", "count/level", cnt, 0);
    chk(tx_full == 0 && rdata == 0, "R1", "tx_full/rx_data", {tx_full, rdata}, 0);

    // three-entry queue, no hold
    snap_cs = cs_rises;
    push_ent(8'h3C, 0, 0, 0, 1);
    push_ent(8'hC5, 0, 0, 0, 1);
    push_ent(8'h81, 1, 0, 0, 1);
    wait_eoq();
    chk(running == 0, "R7", "stopped after last", running, 0);
    chk(cnt == 3, "R5", "count after 3 frames", cnt, 3);
    chk(cs_rises - snap_cs == 3, "R10", "cs release per frame", cs_rises - snap_cs, 3);
    chk(rlevel == 3 && avail == 1, "R11", "rx level 3", rlevel, 3);
    repeat (3) pop_chk();
    @(negedge clk);
    chk(rlevel == 0 && avail == 0, "R11", "rx drained", rlevel, 0);
    chk(rdata == 0, "R3", "empty read zero", rdata, 0);
    pop = 1; @(negedge clk); pop = 0; @(negedge clk);
    chk(rlevel == 0 && rdata == 0, "R3", "pop on empty", rlevel, 0);

    // while stopped: fill TX, overflow push dropped, hold bridge
    push_ent(8'hA1, 0, 0, 1, 1);
    push_ent(8'h5E, 0, 0, 0, 1);
    push_ent(8'h0F, 0, 0, 0, 1);
    push_ent(8'hF0, 1, 0, 0, 1);
    @(negedge clk);
    chk(tx_full == 1, "R4", "tx full at 4", tx_full, 1);
    push_ent(8'h77, 0, 0, 0, 0);
    snap_tot = tot;
    repeat (200) @(negedge clk);
    chk(tot == snap_tot && csn == 1 && eoq == 1, "R7", "no activity while stopped", tot, snap_tot);
    snap_cs = cs_rises;
    pulse_clr();
    chk(running == 1 && eoq == 0, "R8", "restart after clear", running, 1);
    wait_eoq();
    chk(cs_rises - snap_cs == 3, "R10", "hold bridges frames", cs_rises - snap_cs, 3);
    chk(cnt == 7, "R5", "count after 7 frames", cnt, 7);
    chk(tx_full == 0 && exp_mosi.size() == 0, "R4", "dropped push not sent", exp_mosi.size(), 0);
    chk(rlevel == 4, "R11", "rx level at depth", rlevel, 4);
    repeat (4) pop_chk();

    // flush and counter write / zero bit
    push_ent(8'h11, 0, 0, 0, 0);
    push_ent(8'h22, 0, 0, 0, 0);
    @(negedge clk); tflush = 1; push = 1; tdata = 8'h33;
    @(negedge clk); tflush = 0; push = 0;
    write_cnt(16'h1234);
    chk(cnt == 16'h1234, "R5", "counter write", cnt, 16'h1234);
    push_ent(8'h9B, 1, 1, 0, 1);
    pulse_clr();
    wait_eoq();
    chk(cnt == 1, "R6", "zero bit restarts count", cnt, 1);
    chk(exp_mosi.size() == 0 && tot == 64, "R9", "flushed entries not sent", tot, 64);
    chk(rlevel == 1, "R9", "one word after flush run", rlevel, 1);
    @(negedge clk); rflush = 1;
    @(negedge clk); rflush = 0; exp_rx.delete();
    chk(rlevel == 0 && avail == 0, "R9", "rx flush", rlevel, 0);

    // divisor 0 and counter wrap
    div_b = 8'd0;
    write_cnt(16'hFFFF);
    push_ent(8'hE7, 1, 0, 0, 1);
    pulse_clr();
    wait_eoq();
    chk(cnt == 0, "R5", "wrap to zero", cnt, 0);
    pop_chk();

    // divisor 3, hold with last still releases select
    div_b = 8'd3;
    push_ent(8'h96, 1, 0, 1, 1);
    pulse_clr();
    wait_eoq();
    @(negedge clk);
    chk(csn == 1, "R10", "last releases held select", csn, 1);
    pop_chk();
    chk(exp_mosi.size() == 0, "R2", "all frames seen", exp_mosi.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule